// File: doc/BRIEF.md
# Programmable SPI Byte Engine

This block lets software compose any SPI flash command one byte at a time. Software holds a chip-select control word in a register. When that word selects user mode and its stop flag is clear, the chip select is asserted. Each byte then written through the byte window is shifted out on the SPI pins. Each read through the window shifts one byte in from the flash.

The number of IO lanes can be changed between bytes while the chip select stays asserted. One framed command can therefore carry a single-lane opcode, address and dummy bytes, followed by dual-lane or quad-lane data. Keeping the opcode, address and dummy bytes on one lane is left to software. Setting the stop flag again ends the frame.

Window accesses hold the requester with a busy flag until the byte has been shifted. The clock is SPI mode 0: SCK idles low, the engine samples on the rising edge and changes its outputs on the falling edge.

Top module: `spi_user_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `spi_io_oe` is 0, `win_busy` is 0 and the control register reads back 32'h0000_0004.
- R2: The control register keeps only bits 30 (quad), 29 (dual), 2 (stop) and 1:0 (mode), and other bits read 0. `spi_cs_n` is low exactly when mode equals 3 and stop is 0.
- R3: With neither lane bit set, a window write shifts the byte MSB first on `spi_io_out[0]` over 8 SCK pulses, with `spi_io_oe` = 4'b0001. Data is stable at each rising edge.
- R4: With bit 29 set and bit 30 clear, a window write sends 2 bits per clock on `spi_io_out[1:0]` over 4 SCK pulses. `io[1]` carries the more significant bit and `spi_io_oe` = 4'b0011.
- R5: With bit 30 set (whatever the state of bit 29), a window write sends 4 bits per clock on `spi_io_out[3:0]` over 2 SCK pulses. `io[3]` carries the most significant bit and `spi_io_oe` = 4'b1111.
- R6: In single-lane mode, a window read samples `spi_io_in[1]` on each of 8 rising SCK edges, MSB first. `spi_io_oe` stays 4'b0001 and the byte is on `win_rdata` in the cycle `win_done` is high.
- R7: In dual-lane and quad-lane modes, a window read releases all IO pins (`spi_io_oe` = 0). It samples `io[1:0]` or `io[3:0]` on each rising edge, with the highest lane as the most significant bit.
- R8: Rewriting the lane bits between two window accesses, with the chip select held asserted, changes the width of the following byte only. `spi_cs_n` does not rise.
- R9: A window access while the stop flag is set or mode is not 3 produces no SCK edge. `win_done` pulses in the next cycle, and a read in that state returns 0.
- R10: `win_busy` is high from the cycle after an accepted access until `win_done`. Window requests and register writes made while busy are ignored, and `win_done` lasts one cycle.
- R11: SCK is low whenever no byte is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register readback |
| win_wr | input | 1 | Window write request (one-cycle pulse) |
| win_rd | input | 1 | Window read request (one-cycle pulse) |
| win_wdata | input | 8 | Byte to shift out |
| win_rdata | output | 8 | Last byte shifted in, or 0 after an ignored read |
| win_busy | output | 1 | Byte shift in progress; requester must wait |
| win_done | output | 1 | One-cycle completion pulse |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_io_out | output | 4 | IO lane output values |
| spi_io_oe | output | 4 | IO lane output enables |
| spi_io_in | input | 4 | IO lane input values |

## Verification
The embedded assertions watch several properties on every cycle:
- SCK stays low outside a shift.
- The chip select is asserted throughout a shift.
- All IO drivers are released during multi-lane reads.
- The completion flag never lasts two cycles.
- The control word is frozen while busy.

Bit order, lane mapping, the number of SCK pulses per width, width switching inside one frame, and the zero returned by ignored reads all depend on data values. Only the bench's flash model can show these, by capturing and supplying bytes on the pins in directed and random scenarios.

// File: rtl/spiu_pkg.sv
`timescale 1ns/1ps
package spiu_pkg;

  typedef enum logic [1:0] {
    LW_SINGLE = 2'd0,
    LW_DUAL   = 2'd1,
    LW_QUAD   = 2'd2
  } lane_w_e;

  localparam int CTRL_W     = 32;
  localparam int BIT_QUAD   = 30;
  localparam int BIT_DUAL   = 29;
  localparam int BIT_STOP   = 2;
  localparam logic [1:0] MODE_USER = 2'b11;
  localparam logic [CTRL_W-1:0] CTRL_KEEP  = 32'h6000_0007;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 32'h0000_0004;

  // Quad has precedence over dual.
  function automatic lane_w_e decode_width(input logic [CTRL_W-1:0] c);
    if (c[BIT_QUAD])      return LW_QUAD;
    else if (c[BIT_DUAL]) return LW_DUAL;
    else                  return LW_SINGLE;
  endfunction

  // Two SCK edges per bit group.
  function automatic logic [4:0] edges_per_byte(input lane_w_e w);
    case (w)
      LW_DUAL: return 5'd8;
      LW_QUAD: return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic [3:0] drive_lanes(input logic [7:0] sr, input lane_w_e w);
    case (w)
      LW_DUAL: return {2'b00, sr[7:6]};
      LW_QUAD: return sr[7:4];
      default: return {3'b000, sr[7]};
    endcase
  endfunction

  function automatic logic [7:0] shift_out(input logic [7:0] sr, input lane_w_e w);
    case (w)
      LW_DUAL: return {sr[5:0], 2'b00};
      LW_QUAD: return {sr[3:0], 4'b0000};
      default: return {sr[6:0], 1'b0};
    endcase
  endfunction

  function automatic logic [7:0] merge_in(input logic [7:0] rx, input logic [3:0] io,
                                          input lane_w_e w);
    case (w)
      LW_DUAL: return {rx[5:0], io[1:0]};
      LW_QUAD: return {rx[3:0], io[3:0]};
      default: return {rx[6:0], io[1]};
    endcase
  endfunction

  function automatic logic [3:0] out_enable(input lane_w_e w, input logic rd);
    case (w)
      LW_DUAL: return rd ? 4'b0000 : 4'b0011;
      LW_QUAD: return rd ? 4'b0000 : 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

endpackage

// File: rtl/spiu_ctrl_reg.sv
`timescale 1ns/1ps
module spiu_ctrl_reg
  import spiu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              busy,
  output logic [CTRL_W-1:0] rdata,
  output logic              active,
  output lane_w_e           width
);

  logic [CTRL_W-1:0] ctrl_q;
  logic              wr_accept;

  assign wr_accept = wr && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ctrl_q <= CTRL_RESET;
    else if (wr_accept)  ctrl_q <= wdata & CTRL_KEEP;
  end

  assign rdata  = ctrl_q;
  assign active = (ctrl_q[1:0] == MODE_USER) && !ctrl_q[BIT_STOP];
  assign width  = decode_width(ctrl_q);

  // R10: control word frozen while a byte is in flight
  assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctrl_q));

endmodule

// File: rtl/spiu_byte_shifter.sv
`timescale 1ns/1ps
module spiu_byte_shifter
  import spiu_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_rd,
  input  lane_w_e    width,
  input  logic [7:0] wbyte,
  input  logic       clr_rx,
  input  logic [3:0] io_in,
  output logic       busy,
  output logic       done,
  output logic       sck,
  output logic [3:0] io_out,
  output logic [3:0] io_oe,
  output logic [7:0] rx_byte
);

  localparam int HCW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HCW-1:0] HC_LAST = HCW'(HALF_DIV - 1);

  logic [7:0]     sr_q, rx_q;
  logic [HCW-1:0] hcnt_q;
  logic [4:0]     edges_q;
  logic           rd_q;
  lane_w_e        w_q;
  logic           half_tick;
  logic           rise_evt;

  assign half_tick = busy && (hcnt_q == HC_LAST);
  assign rise_evt  = half_tick && !sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sck     <= 1'b0;
      sr_q    <= '0;
      rx_q    <= '0;
      hcnt_q  <= '0;
      edges_q <= '0;
      rd_q    <= 1'b0;
      w_q     <= LW_SINGLE;
    end else begin
      done <= 1'b0;
      if (clr_rx) rx_q <= '0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          sr_q    <= is_rd ? 8'h00 : wbyte;
          rd_q    <= is_rd;
          w_q     <= width;
          edges_q <= edges_per_byte(width);
          hcnt_q  <= '0;
        end
      end else if (half_tick) begin
        hcnt_q  <= '0;
        sck     <= ~sck;
        edges_q <= edges_q - 5'd1;
        if (!sck) rx_q <= merge_in(rx_q, io_in, w_q);
        else      sr_q <= shift_out(sr_q, w_q);
        if (edges_q == 5'd1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  assign io_out  = busy ? drive_lanes(sr_q, w_q) : 4'b0000;
  assign io_oe   = busy ? out_enable(w_q, rd_q) : 4'b0000;
  assign rx_byte = rx_q;

  // R11: SCK rests low outside a shift
  assert_sck_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: multi-lane reads release every IO driver
  assert_multi_read_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_q && (w_q != LW_SINGLE)) |-> (io_oe == 4'b0000));
  // R3: a rising edge never coincides with an output change
  assert_rise_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> $stable(sr_q));

endmodule

// File: rtl/spi_user_engine.sv
`timescale 1ns/1ps
module spi_user_engine
  import spiu_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        win_wr,
  input  logic        win_rd,
  input  logic [7:0]  win_wdata,
  output logic [7:0]  win_rdata,
  output logic        win_busy,
  output logic        win_done,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic [3:0]  spi_io_out,
  output logic [3:0]  spi_io_oe,
  input  logic [3:0]  spi_io_in
);

  logic    busy, shift_done, active;
  lane_w_e width;
  logic    req, accept, start_evt, ignore_evt;
  logic    ign_done_q;

  assign req        = win_wr || win_rd;
  assign accept     = req && !busy;
  assign start_evt  = accept && active;
  assign ignore_evt = accept && !active;

  spiu_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .busy   (busy),
    .rdata  (reg_rdata),
    .active (active),
    .width  (width)
  );

  spiu_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_evt),
    .is_rd   (win_rd),
    .width   (width),
    .wbyte   (win_wdata),
    .clr_rx  (ignore_evt),
    .io_in   (spi_io_in),
    .busy    (busy),
    .done    (shift_done),
    .sck     (spi_sck),
    .io_out  (spi_io_out),
    .io_oe   (spi_io_oe),
    .rx_byte (win_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ign_done_q <= 1'b0;
    else        ign_done_q <= ignore_evt;
  end

  assign spi_cs_n = !active;
  assign win_busy = busy;
  assign win_done = shift_done || ign_done_q;

  // R2: chip select held asserted for the whole byte
  assert_cs_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !spi_cs_n);
  // R9: an ignored access completes without clocking the bus
  assert_ignored_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ignore_evt |=> (!busy && !spi_sck && win_done));

endmodule

// File: tb/sim_spi_user_engine.sv
`timescale 1ns/1ps
module sim_spi_user_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        win_wr = 1'b0, win_rd = 1'b0;
  logic [7:0]  win_wdata = '0;
  logic [7:0]  win_rdata;
  logic        win_busy, win_done;
  logic        spi_sck, spi_cs_n;
  logic [3:0]  spi_io_out, spi_io_oe, spi_io_in;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench-side flash model state
  int       cur_w = 0;          // 0 single, 1 dual, 2 quad
  logic [7:0] cap = '0;
  int       redges = 0;
  bit       oe_bad = 0;
  logic [3:0] exp_oe = '0;
  logic [7:0] mdl_sr = '0;
  int       cs_rises = 0;

  always #10 clk = ~clk;

  spi_user_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .win_wr(win_wr), .win_rd(win_rd),
    .win_wdata(win_wdata), .win_rdata(win_rdata), .win_busy(win_busy),
    .win_done(win_done), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
  );

  assign spi_io_in = (cur_w == 2) ? mdl_sr[7:4] :
                     (cur_w == 1) ? {2'b00, mdl_sr[7:6]} :
                                    {2'b00, mdl_sr[7], 1'b0};

  always @(posedge spi_sck) begin
    redges = redges + 1;
    if (cur_w == 2)      cap = {cap[3:0], spi_io_out[3:0]};
    else if (cur_w == 1) cap = {cap[5:0], spi_io_out[1:0]};
    else                 cap = {cap[6:0], spi_io_out[0]};
    if (spi_io_oe !== exp_oe) oe_bad = 1;
  end

  always @(negedge spi_sck) begin
    if (cur_w == 2)      mdl_sr = {mdl_sr[3:0], 4'h0};
    else if (cur_w == 1) mdl_sr = {mdl_sr[5:0], 2'b00};
    else                 mdl_sr = {mdl_sr[6:0], 1'b0};
  end

  always @(posedge spi_cs_n) cs_rises = cs_rises + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(input int w, input bit stop);
    logic [31:0] v;
    v = 32'h3;
    if (stop) v[2] = 1'b1;
    if (w == 1) v[29] = 1'b1;
    if (w == 2) v[30] = 1'b1;
    return v;
  endfunction

  function automatic int pulses_for(input int w);
    return (w == 2) ? 2 : (w == 1) ? 4 : 8;
  endfunction

  function automatic logic [3:0] oe_for(input int w, input bit rd);
    if (w == 0) return 4'b0001;
    if (rd)     return 4'b0000;
    return (w == 1) ? 4'b0011 : 4'b1111;
  endfunction

  task automatic reg_write(input logic [31:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic xfer(input bit rd, input int w, input logic [7:0] b,
                      output logic [7:0] got, output int ncyc);
    cur_w = w; cap = '0; redges = 0; oe_bad = 0; exp_oe = oe_for(w, rd);
    if (rd) mdl_sr = b;
    @(negedge clk); win_wr = !rd; win_rd = rd; win_wdata = b;
    @(negedge clk); win_wr = 1'b0; win_rd = 1'b0; ncyc = 1;
    while (!win_done && ncyc < 300) begin @(negedge clk); ncyc++; end
    got = win_rdata;
    if (ncyc >= 300) chk(0, "R10 done timeout", ncyc, 0);
  endtask

  task automatic full_check(input bit rd, input int w, input logic [7:0] b,
                            input string req);
    logic [7:0] got; int n;
    xfer(rd, w, b, got, n);
    if (rd) chk(got == b, req, got, b);
    else    chk(cap == b, req, cap, b);
    chk(redges == pulses_for(w), req, redges, pulses_for(w));
    chk(!oe_bad, req, oe_bad, 0);
    chk(spi_sck == 1'b0, "R11", spi_sck, 0);
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] got; int n; int r0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1 && spi_sck == 0 && spi_io_oe == 0 && win_busy == 0,
        "R1", {spi_cs_n, spi_sck, spi_io_oe, win_busy}, 7'b1000000);
    chk(reg_rdata == 32'h4, "R1", reg_rdata, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 readback masking and chip-select decode
    reg_write(32'hFFFF_FFFF);
    chk(reg_rdata == 32'h6000_0007, "R2", reg_rdata, 32'h6000_0007);
    chk(spi_cs_n == 1, "R2", spi_cs_n, 1);
    reg_write(32'h0000_0001);
    chk(spi_cs_n == 1, "R2", spi_cs_n, 1);
    reg_write(32'h0000_0003);
    chk(spi_cs_n == 0, "R2", spi_cs_n, 0);

    // R3 R4 R5 writes
    full_check(0, 0, 8'hA5, "R3");
    reg_write(ctrl_word(1, 0));
    full_check(0, 1, 8'h3C, "R4");
    reg_write(ctrl_word(2, 0) | 32'h2000_0000);  // both lane bits: quad wins
    full_check(0, 2, 8'h96, "R5");

    // R6 R7 reads
    reg_write(ctrl_word(0, 0));
    full_check(1, 0, 8'hC3, "R6");
    reg_write(ctrl_word(1, 0));
    full_check(1, 1, 8'h5A, "R7");
    reg_write(ctrl_word(2, 0));
    full_check(1, 2, 8'hE1, "R7");

    // R9 ignored accesses (rx currently holds 0xE1)
    reg_write(ctrl_word(0, 1));
    xfer(0, 0, 8'hFF, got, n);
    chk(redges == 0 && n == 1, "R9", redges, 0);
    xfer(1, 0, 8'h77, got, n);
    chk(got == 8'h00 && redges == 0 && n == 1, "R9", got, 0);
    reg_write(32'h0000_0002);
    xfer(1, 0, 8'h77, got, n);
    chk(got == 8'h00 && redges == 0, "R9", got, 0);

    // R8 width switch within one frame
    reg_write(ctrl_word(0, 0));
    r0 = cs_rises;
    full_check(0, 0, 8'h0B, "R8");
    reg_write(ctrl_word(2, 0));
    full_check(0, 2, 8'hD4, "R8");
    reg_write(ctrl_word(1, 0));
    full_check(1, 1, 8'h6E, "R8");
    chk(cs_rises == r0 && spi_cs_n == 0, "R8", cs_rises - r0, 0);

    // R10 requests and register writes during busy are ignored
    reg_write(ctrl_word(0, 0));
    cur_w = 0; cap = '0; redges = 0; oe_bad = 0; exp_oe = 4'b0001;
    @(negedge clk); win_wr = 1'b1; win_wdata = 8'h81;
    @(negedge clk); win_wr = 1'b0; win_wdata = 8'hFF;
    chk(win_busy == 1, "R10", win_busy, 1);
    @(negedge clk); win_wr = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h7;
    @(negedge clk); win_wr = 1'b0; reg_wr = 1'b0;
    n = 0;
    while (!win_done && n < 300) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(win_done == 0, "R10", win_done, 0);
    repeat (20) @(negedge clk);
    chk(cap == 8'h81 && redges == 8, "R10", cap, 8'h81);
    chk(reg_rdata == 32'h3 && spi_cs_n == 0, "R10", reg_rdata, 32'h3);

    // random mix
    for (int i = 0; i < 60; i++) begin
      int w; bit rd; logic [7:0] b;
      w  = int'($urandom_range(0, 2));
      rd = 1'($urandom_range(0, 1));
      b  = 8'($urandom);
      reg_write(ctrl_word(w, 0));
      full_check(rd, w, b, rd ? ((w == 0) ? "R6" : "R7")
                               : ((w == 0) ? "R3" : (w == 1) ? "R4" : "R5"));
    end

    reg_write(ctrl_word(0, 1));
    chk(spi_cs_n == 1, "R2", spi_cs_n, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule